// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the memory-mapped state store of a small interrupt controller. For every interrupt line it keeps an enable bit, a pending bit, an active bit, an 8-bit priority and a 2-bit trigger field. A global control bit gates forwarding, and a read-only type word reports how many lines are built. Software reaches all of it through a simple 32-bit bus. The bus has a byte-lane strobe and a combinational read path.

The three state bits are never written directly. Each has one window whose ones set bits and a second window whose ones clear bits, so software can change a single line without a read-modify-write. Priorities are packed four to a word and can be written one byte at a time. The interrupt inputs set pending bits by themselves, either by level or by rising edge, as each line's trigger field selects. The enable, pending and priority state of every line is exported as flat vectors for a CPU-side selector. A short busy flag in the control word tells software when a recent enable or control update is still settling.

Top module: `irq_dist_bank`

## Requirements
- R1: After reset every enable, pending and active bit is 0, and every priority and trigger field is 0. The control word reads 0.
- R2: Enable bits are set by writing ones at 0x100 + 4*(n>>5) and cleared by writing ones at 0x180 + 4*(n>>5), using bit n%32. Zero bits have no effect. Both windows read back the current enable bits.
- R3: Pending bits use the same scheme with set window 0x200 and clear window 0x280. Active bits use set window 0x300 and clear window 0x380.
- R4: In every write, bus_be[i] enables data bits 8i+7..8i. Data in a lane whose strobe is low is ignored.
- R5: The priority of line n is the byte at 0x400 + n, in byte lane n%4 of word 0x400 + 4*(n>>2). A write changes only the lines whose lanes are strobed.
- R6: The trigger field of line n is at bits 2*(n%16)+1..2*(n%16) of word 0xC00 + 4*(n>>4). Both bits are stored and read back. Field bit 1 = 1 selects rising-edge trigger; 0 selects level trigger.
- R7: A level-triggered line sets its pending bit on every clock edge where its input is high, so the bit reads 1 from the next cycle on. A clear written while the input is high leaves the bit at 1.
- R8: An edge-triggered line sets pending only where its input is high and was low at the previous clock edge. After the bit is cleared, an input that stays high does not set it again.
- R9: Bit 0 of the control word at 0x000 is read/write and drives fwd_en.
- R10: Bit 31 of the control word reads 1 during the two cycles that follow a write to the control word or to either enable window, and reads 0 after that. A further such write restarts the two-cycle count.
- R11: The type word at 0x004 reads NUM_LINES/32-1 in bits 4..0 and 0 elsewhere, and ignores writes. State words, priority bytes or trigger words for lines that are not built read 0 and ignore writes. Unmapped addresses read 0. Accesses with bus_addr[1:0] not 00 are ignored and read 0.
- R12: The outputs line_en, line_pend and line_prio (8 bits per line, line n at bits 8n+7..8n) always equal the stored state of each line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | NUM_LINES | Interrupt inputs |
| fwd_en | output | 1 | Global forwarding enable |
| line_en | output | NUM_LINES | Enable bit per line |
| line_pend | output | NUM_LINES | Pending bit per line |
| line_prio | output | 8*NUM_LINES | Priority per line |

## Verification
The bench sweeps every line through the set and clear windows of all three state bits. A decoder that swapped word or bit indexing, or that let zero bits clear state, would mismatch in that sweep. Each priority byte is written on its own with a unique value and the whole array is read back, so a lane-decode fault that spills into a neighbouring line is caught. The trigger corner cases are each exercised. A level input that is high must defeat a software clear. An edge input that is held high must not re-pend after a clear. The busy flag is sampled on its first, second and third cycle after a write, which exposes an off-by-one window. Writes beyond the built lines, to the type word and at misaligned addresses must leave everything unchanged.

// File: rtl/irq_dist_bank.sv
module irq_dist_bank #(
  parameter int NUM_LINES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [11:0]            bus_addr,
  input  logic                   bus_wr,
  input  logic [3:0]             bus_be,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_LINES-1:0]   irq_in,
  output logic                   fwd_en,
  output logic [NUM_LINES-1:0]   line_en,
  output logic [NUM_LINES-1:0]   line_pend,
  output logic [NUM_LINES*8-1:0] line_prio
);
  localparam int NW       = NUM_LINES / 32;
  localparam int NPW      = NUM_LINES / 4;
  localparam int NCW      = NUM_LINES / 16;
  localparam int WAIT_CYC = 2;

  logic        aligned, wr_ok;
  logic [31:0] lane_mask, wbits;
  logic [4:0]  region, widx;
  logic        ctrl_hit, type_hit, prio_hit, cfg_hit;
  logic [7:0]  pidx;
  logic [5:0]  cidx;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign wr_ok     = bus_wr && aligned;
  assign lane_mask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  assign wbits     = bus_wdata & lane_mask;
  assign region    = bus_addr[11:7];
  assign widx      = bus_addr[6:2];
  assign ctrl_hit  = (bus_addr[11:2] == 10'd0);
  assign type_hit  = (bus_addr[11:2] == 10'd1);
  assign prio_hit  = (bus_addr[11:10] == 2'b01);
  assign cfg_hit   = (bus_addr[11:8] == 4'hC);
  assign pidx      = bus_addr[9:2];
  assign cidx      = bus_addr[7:2];

  logic [NUM_LINES-1:0] en_q, pend_q, act_q, irq_q, edge_mode, hw_set;
  logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr;
  logic [1:0]           cfg_q  [NUM_LINES];
  logic [7:0]           prio_q [NUM_LINES];
  logic                 grp_en_q;
  logic [1:0]           busy_cnt;

  always_comb begin
    en_set = '0; en_clr = '0;
    pd_set = '0; pd_clr = '0;
    ac_set = '0; ac_clr = '0;
    if (wr_ok) begin
      for (int w = 0; w < NW; w++) begin
        if (widx == 5'(w)) begin
          case (region)
            5'd2: en_set[w*32 +: 32] = wbits;
            5'd3: en_clr[w*32 +: 32] = wbits;
            5'd4: pd_set[w*32 +: 32] = wbits;
            5'd5: pd_clr[w*32 +: 32] = wbits;
            5'd6: ac_set[w*32 +: 32] = wbits;
            5'd7: ac_clr[w*32 +: 32] = wbits;
            default: ;
          endcase
        end
      end
    end
  end

  assign hw_set = irq_in & (~edge_mode | ~irq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      pend_q   <= '0;
      act_q    <= '0;
      irq_q    <= '0;
      grp_en_q <= 1'b0;
      busy_cnt <= '0;
    end else begin
      en_q   <= (en_q & ~en_clr) | en_set;
      pend_q <= (pend_q & ~pd_clr) | pd_set | hw_set;
      act_q  <= (act_q & ~ac_clr) | ac_set;
      irq_q  <= irq_in;
      if (wr_ok && ctrl_hit && bus_be[0])
        grp_en_q <= bus_wdata[0];
      if (wr_ok && (ctrl_hit || region == 5'd2 || region == 5'd3))
        busy_cnt <= 2'(WAIT_CYC);
      else if (busy_cnt != 2'd0)
        busy_cnt <= busy_cnt - 2'd1;
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int PL   = n % 4;
    localparam int CL   = (n % 16) / 4;
    localparam int CPOS = 2 * (n % 16);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[n] <= '0;
        cfg_q[n]  <= '0;
      end else begin
        if (wr_ok && prio_hit && pidx == 8'(n / 4) && bus_be[PL])
          prio_q[n] <= bus_wdata[8*PL +: 8];
        if (wr_ok && cfg_hit && cidx == 6'(n / 16) && bus_be[CL])
          cfg_q[n] <= bus_wdata[CPOS +: 2];
      end
    end

    assign edge_mode[n]        = cfg_q[n][1];
    assign line_prio[8*n +: 8] = prio_q[n];
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (ctrl_hit) begin
        bus_rdata = {(busy_cnt != 2'd0), 30'd0, grp_en_q};
      end else if (type_hit) begin
        bus_rdata = 32'(NW - 1);
      end else if (region >= 5'd2 && region <= 5'd7) begin
        for (int w = 0; w < NW; w++) begin
          if (widx == 5'(w)) begin
            case (region)
              5'd2, 5'd3: bus_rdata = en_q[w*32 +: 32];
              5'd4, 5'd5: bus_rdata = pend_q[w*32 +: 32];
              default:    bus_rdata = act_q[w*32 +: 32];
            endcase
          end
        end
      end else if (prio_hit) begin
        for (int k = 0; k < NPW; k++)
          if (pidx == 8'(k))
            bus_rdata = {prio_q[4*k+3], prio_q[4*k+2], prio_q[4*k+1], prio_q[4*k]};
      end else if (cfg_hit) begin
        for (int k = 0; k < NCW; k++)
          if (cidx == 6'(k))
            for (int j = 0; j < 16; j++)
              bus_rdata[2*j +: 2] = cfg_q[16*k + j];
      end
    end
  end

  assign fwd_en    = grp_en_q;
  assign line_en   = en_q;
  assign line_pend = pend_q;
endmodule

// File: rtl/irq_dist_bank_chk.sv
module irq_dist_bank_chk #(
  parameter int NUM_LINES = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [11:0]            bus_addr,
  input logic                   bus_wr,
  input logic [3:0]             bus_be,
  input logic [31:0]            bus_wdata,
  input logic [NUM_LINES-1:0]   irq_in,
  input logic [NUM_LINES-1:0]   line_en,
  input logic [NUM_LINES-1:0]   line_pend,
  input logic [NUM_LINES*8-1:0] line_prio,
  input logic [NUM_LINES-1:0]   edge_mode,
  input logic [1:0]             busy_cnt
);
  a_r2_set_word0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 12'h100 && bus_be == 4'hF
    |=> line_en[31:0] == ($past(line_en[31:0]) | $past(bus_wdata)));

  a_r2_clr_word0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 12'h180 && bus_be == 4'hF
    |=> line_en[31:0] == ($past(line_en[31:0]) & ~$past(bus_wdata)));

  a_r12_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(line_en));

  a_r5_prio_neighbors: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 12'h400 && bus_be == 4'b0001
    |=> $stable(line_prio[31:8]));

  a_r7_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode[0] && irq_in[0] |=> line_pend[0]);

  a_r10_busy_two: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 12'h000 |=> (busy_cnt != 2'd0) ##1 (busy_cnt != 2'd0));
endmodule

bind irq_dist_bank irq_dist_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .irq_in(irq_in),
  .line_en(line_en), .line_pend(line_pend), .line_prio(line_prio),
  .edge_mode(edge_mode), .busy_cnt(busy_cnt)
);

// File: tb/test_irq_dist_bank.sv
module test_irq_dist_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_be = 4'hF;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic          fwd_en;
  logic [N-1:0]  line_en, line_pend;
  logic [N*8-1:0] line_prio;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dist_bank #(.NUM_LINES(N)) i_irq_dist_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .fwd_en(fwd_en), .line_en(line_en),
    .line_pend(line_pend), .line_prio(line_prio)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] pval(input int n);
    return 8'(n * 37 + 11);
  endfunction

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [11:0] base_s, base_c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R11 type word
    rd(12'h000, d); chk("R1 ctrl", d, 32'h0);
    rd(12'h004, d); chk("R11 type", d, 32'd1);
    rd(12'h100, d); chk("R1 enable", d, 32'h0);
    rd(12'h204, d); chk("R1 pending", d, 32'h0);
    rd(12'h300, d); chk("R1 active", d, 32'h0);
    rd(12'h400, d); chk("R1 prio", d, 32'h0);
    rd(12'hC00, d); chk("R1 cfg", d, 32'h0);
    chk("R1 fwd_en", 32'(fwd_en), 32'h0);

    // R2 and R12: sweep every enable bit
    for (int n = 0; n < N; n++) begin
      logic [N-1:0] one;
      one = '0; one[n] = 1'b1;
      wr(12'h100 + 12'(4 * (n >> 5)), 32'(1) << (n % 32));
      rd(12'h100 + 12'(4 * (n >> 5)), d); chk("R2 set window", d, 32'(1) << (n % 32));
      rd(12'h180 + 12'(4 * (n >> 5)), d); chk("R2 clr window read", d, 32'(1) << (n % 32));
      chk("R12 line_en lo", line_en[31:0], one[31:0]);
      chk("R12 line_en hi", line_en[63:32], one[63:32]);
      wr(12'h180 + 12'(4 * (n >> 5)), 32'(1) << (n % 32));
      rd(12'h100 + 12'(4 * (n >> 5)), d); chk("R2 cleared", d, 32'h0);
    end
    wr(12'h100, 32'h0000_00F0);
    wr(12'h100, 32'h0);
    rd(12'h100, d); chk("R2 zero set no effect", d, 32'h0000_00F0);
    wr(12'h180, 32'h0);
    rd(12'h100, d); chk("R2 zero clear no effect", d, 32'h0000_00F0);
    wr(12'h180, 32'hFFFF_FFFF);

    // R3: pending and active sweep
    for (int n = 0; n < N; n++) begin
      logic [N-1:0] one;
      one = '0; one[n] = 1'b1;
      base_s = 12'h200 + 12'(4 * (n >> 5));
      base_c = 12'h280 + 12'(4 * (n >> 5));
      wr(base_s, 32'(1) << (n % 32));
      rd(base_c, d); chk("R3 pending set", d, 32'(1) << (n % 32));
      chk("R12 line_pend lo", line_pend[31:0], one[31:0]);
      chk("R12 line_pend hi", line_pend[63:32], one[63:32]);
      wr(base_c, 32'(1) << (n % 32));
      rd(base_s, d); chk("R3 pending clear", d, 32'h0);
      base_s = 12'h300 + 12'(4 * (n >> 5));
      base_c = 12'h380 + 12'(4 * (n >> 5));
      wr(base_s, 32'(1) << (n % 32));
      rd(base_c, d); chk("R3 active set", d, 32'(1) << (n % 32));
      wr(base_c, 32'(1) << (n % 32));
      rd(base_s, d); chk("R3 active clear", d, 32'h0);
    end

    // R4 byte lanes
    wr(12'h104, 32'hFFFF_FFFF, 4'b0010);
    rd(12'h104, d); chk("R4 lane 1 only", d, 32'h0000_FF00);
    wr(12'h184, 32'hFFFF_FFFF, 4'b1000);
    rd(12'h104, d); chk("R4 clear lane 3 only", d, 32'h0000_FF00);
    wr(12'h184, 32'hFFFF_FFFF);

    // R5 priority bytes
    for (int n = 0; n < N; n++)
      wr(12'h400 + 12'(n & ~3), 32'(pval(n)) << (8 * (n % 4)), 4'(1 << (n % 4)));
    for (int k = 0; k < N / 4; k++) begin
      rd(12'h400 + 12'(4 * k), d);
      chk("R5 prio word", d, {pval(4*k+3), pval(4*k+2), pval(4*k+1), pval(4*k)});
    end
    for (int n = 0; n < N; n++)
      chk("R12 line_prio", 32'(line_prio[8*n +: 8]), 32'(pval(n)));
    wr(12'h404, 32'h00AB_0000, 4'b0100);
    rd(12'h404, d); chk("R5 single byte", d, {pval(7), 8'hAB, pval(5), pval(4)});

    // R6 trigger fields
    wr(12'hC00, 32'hA5A5_5A5A);
    rd(12'hC00, d); chk("R6 cfg word0", d, 32'hA5A5_5A5A);
    wr(12'hC0C, 32'h1234_8765);
    rd(12'hC0C, d); chk("R6 cfg word3", d, 32'h1234_8765);
    wr(12'hC00, 32'h0);
    wr(12'hC0C, 32'h0);
    wr(12'hC08, 32'h0002_0000);
    rd(12'hC08, d); chk("R6 line 40 edge field", d, 32'h0002_0000);

    // R7 level trigger on line 5
    irq_in[5] = 1'b1;
    @(negedge clk);
    rd(12'h200, d); chk("R7 level sets pending", d, 32'h20);
    wr(12'h280, 32'h20);
    rd(12'h200, d); chk("R7 clear loses to high level", d, 32'h20);
    irq_in[5] = 1'b0;
    wr(12'h280, 32'h20);
    rd(12'h200, d); chk("R7 clear after input low", d, 32'h0);

    // R8 edge trigger on line 40
    irq_in[40] = 1'b1;
    @(negedge clk);
    rd(12'h204, d); chk("R8 rise sets pending", d, 32'h100);
    wr(12'h284, 32'h100);
    rd(12'h204, d); chk("R8 cleared while high", d, 32'h0);
    repeat (2) @(negedge clk);
    rd(12'h204, d); chk("R8 held high no re-pend", d, 32'h0);
    irq_in[40] = 1'b0;
    @(negedge clk);
    rd(12'h204, d); chk("R8 fall no pend", d, 32'h0);
    irq_in[40] = 1'b1;
    @(negedge clk);
    rd(12'h204, d); chk("R8 second rise", d, 32'h100);
    irq_in[40] = 1'b0;
    wr(12'h284, 32'h100);

    // R9 control enable
    wr(12'h000, 32'h1);
    chk("R9 fwd_en on", 32'(fwd_en), 32'h1);
    rd(12'h000, d); chk("R9 ctrl bit0", d & 32'h1, 32'h1);
    wr(12'h000, 32'h0);
    chk("R9 fwd_en off", 32'(fwd_en), 32'h0);

    // R10 busy window after enable write
    repeat (3) @(negedge clk);
    rd(12'h000, d); chk("R10 idle", d, 32'h0);
    wr(12'h100, 32'h0);
    rd(12'h000, d); chk("R10 busy cycle 1", d, 32'h8000_0000);
    @(negedge clk);
    rd(12'h000, d); chk("R10 busy cycle 2", d, 32'h8000_0000);
    @(negedge clk);
    rd(12'h000, d); chk("R10 busy over", d, 32'h0);
    wr(12'h200, 32'h0);
    rd(12'h000, d); chk("R10 pending write no busy", d, 32'h0);
    wr(12'h000, 32'h1);
    @(negedge clk);
    wr(12'h180, 32'h0);
    @(negedge clk);
    rd(12'h000, d); chk("R10 restart", d, 32'h8000_0001);
    wr(12'h000, 32'h0);

    // R11 unbuilt lines, type, unmapped, misaligned
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h108, d); chk("R11 enable word 2", d, 32'h0);
    wr(12'h208, 32'hFFFF_FFFF);
    rd(12'h208, d); chk("R11 pending word 2", d, 32'h0);
    wr(12'h440, 32'hFFFF_FFFF);
    rd(12'h440, d); chk("R11 prio line 64", d, 32'h0);
    wr(12'hC10, 32'hFFFF_FFFF);
    rd(12'hC10, d); chk("R11 cfg word 4", d, 32'h0);
    wr(12'h004, 32'h0);
    rd(12'h004, d); chk("R11 type ignores write", d, 32'd1);
    rd(12'hFFC, d); chk("R11 unmapped", d, 32'h0);
    wr(12'h101, 32'hFFFF_FFFF);
    rd(12'h100, d); chk("R11 misaligned write", d, 32'h0);
    rd(12'h401, d); chk("R11 misaligned read", d, 32'h0);
    chk("R11 line_en", line_en[31:0] | line_en[63:32], 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule